// File: doc/BRIEF.md
# Low-Memory Region Chip-Select Wait-State Controller

This block controls the low-memory region of a 16-bit bus that carries address and data on the same lines. An external decoder reports whether the current access falls in the region, and a bus-cycle start strobe marks each new access. When an access starts and hits the region, the block drives an active-low chip select and steps through four states: an address phase, a programmed number of wait states (0 to 3), and a data phase. When the control register says so, the data phase is stretched until an external ready input is seen high.

During the address phase the block produces a drive enable for the multiplexed lines. A control bit can suppress that drive to save power. A strap pin sampled while reset is held can force the lines to be driven regardless of that bit. The register also holds a pseudo-static RAM enable bit, which the block only stores and presents on an output. Each access uses the settings captured when it starts. A register write made during an access applies from the next access onward.

Top module: `csw_lowmem_ctl`

## Requirements
- R1: After a synchronous active-low reset the register reads back 0xF3B: wait field 11b, ready required, address suppression and the pseudo-static RAM bit both cleared. The chip select is high and the cycle-done output is low.
- R2: A write sets bit 7 (address suppression), bit 6 (pseudo-static RAM enable), bit 2 (1 = ignore external ready) and bits 1..0 (wait count). Bits 11..8 and 5..3 always read back as 1. The output psram_en follows bit 6.
- R3: The chip select goes low in the clock after a start strobe sampled together with a region hit. A start strobe without a hit, or one that arrives while an access is in progress, leaves the chip select unchanged.
- R4: With bit 2 set, the chip select stays low for exactly 2 + W clocks, where W is the wait field.
- R5: With bit 2 clear, the access ends at the end of the first data-phase clock in which ready is high. The chip select stays low for 2 + W + k clocks, where k is the number of data-phase clocks with ready low. Ready seen during wait states does not shorten the access.
- R6: cyc_done is high for exactly one clock: the first clock in which the chip select is high again after an access.
- R7: addr_phase is high only in the first clock of an access. In that clock ad_oe is low when bit 7 is set and the latched strap is high, and high otherwise. Outside the address phase ad_oe is low.
- R8: The strap value present in the last clock of reset is held until the next reset. When that value is low, ad_oe is high in every address phase, whatever bit 7 says.
- R9: A register write made during an access does not change that access's length or drive behaviour. The new value takes effect from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_pin | input | 1 | Bus-enable strap, captured while reset is held |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 12 | Register write data |
| cfg_rdata | output | 12 | Register read data |
| psram_en | output | 1 | Stored pseudo-static RAM enable bit |
| cyc_start | input | 1 | Start-of-bus-cycle strobe |
| addr_hit | input | 1 | Address falls inside the low-memory region |
| ready_in | input | 1 | External ready |
| lcs_n | output | 1 | Region chip select, active low |
| addr_phase | output | 1 | High in the address phase of an access |
| ad_oe | output | 1 | Drive enable for the address/data lines in the address phase |
| cyc_done | output | 1 | One-clock pulse after an access completes |

## Verification
The hardest case to reach from the ports is a register write, or a second start strobe, that arrives in the middle of a long access. The access must keep its captured length and must not restart. A directed test starts a three-wait access and, in its second clock, writes a zero-wait setting and pulses the start strobe again. The bench then expects the original length, no further chip select, and the new length on the following access. The strap override only shows up across two resets with opposite strap values, so the bench resets once with the strap high and once with it low. In both runs it toggles the strap after reset to show that the value was latched. Random register values and per-clock random ready patterns cover the mix of wait counts and late ready.

// File: rtl/csw_pkg.sv
// Package: shared constants and types for the low-memory chip-select controller.
// Assumes a 12-bit control register with fixed control-bit positions.
package csw_pkg;
    localparam int WS_W    = 2;
    localparam int CFG_W   = 12;
    localparam int BIT_DA  = 7;
    localparam int BIT_PSE = 6;
    localparam int BIT_RDY = 2;

    typedef struct packed {
        logic            da;
        logic            pse;
        logic            rdy_ign;
        logic [WS_W-1:0] ws;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_DATA = 2'd3
    } bus_state_t;
endpackage

// File: rtl/csw_cfg_reg.sv
// Module: control register for the region. Stores the writable fields and
// returns ones on the reserved positions. Assumes single-cycle write strobes.
module csw_cfg_reg
    import csw_pkg::*;
#(
    parameter logic [WS_W-1:0] RST_WS = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic [CFG_W-1:0] rdata
);
    cfg_t cfg_q;
    logic unused_resv;

    assign unused_resv = ^{wdata[CFG_W-1:BIT_DA+1], wdata[BIT_PSE-1:BIT_RDY+1]};

    // Register update: reset to slow, ready-required defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.da      <= 1'b0;
            cfg_q.pse     <= 1'b0;
            cfg_q.rdy_ign <= 1'b0;
            cfg_q.ws      <= RST_WS;
        end else if (wr_en) begin
            cfg_q.da      <= wdata[BIT_DA];
            cfg_q.pse     <= wdata[BIT_PSE];
            cfg_q.rdy_ign <= wdata[BIT_RDY];
            cfg_q.ws      <= wdata[WS_W-1:0];
        end
    end

    // Read view: reserved positions forced high.
    always_comb begin
        rdata          = '1;
        rdata[BIT_DA]  = cfg_q.da;
        rdata[BIT_PSE] = cfg_q.pse;
        rdata[BIT_RDY] = cfg_q.rdy_ign;
        rdata[WS_W-1:0] = cfg_q.ws;
    end

    assign cfg = cfg_q;

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata[BIT_DA] == $past(wdata[BIT_DA])) &&
                  (rdata[WS_W-1:0] == $past(wdata[WS_W-1:0])));
endmodule

// File: rtl/csw_strap_latch.sv
// Module: captures the bus-enable strap while reset is held. The value from
// the last reset clock is kept. Assumes the strap is stable near reset release.
module csw_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_pin,
    output logic strap_hi
);
    logic strap_q;

    // Capture: follow the pin only while reset is active.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_pin;
    end

    assign strap_hi = strap_q;

    assert_strap_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));
endmodule

// File: rtl/csw_bus_seq.sv
// Module: per-access sequencer. Captures the settings at access start, then
// runs the address phase, the wait states and the data phase, and raises
// cycle-done. Assumes start strobes are ignored while an access runs.
module csw_bus_seq
    import csw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_start,
    input  logic            addr_hit,
    input  logic            ready_in,
    input  logic [WS_W-1:0] ws,
    input  logic            rdy_ign,
    input  logic            suppress,
    output logic            lcs_n,
    output logic            addr_phase,
    output logic            ad_oe,
    output logic            cyc_done
);
    bus_state_t      state;
    logic [WS_W-1:0] ws_snap;
    logic [WS_W-1:0] wcnt;
    logic            ign_snap;
    logic            sup_snap;
    logic            done_q;
    logic            data_end;

    assign data_end = (state == ST_DATA) && (ign_snap || ready_in);

    // Sequencer: state, wait counter and captured settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ws_snap  <= '0;
            wcnt     <= '0;
            ign_snap <= 1'b0;
            sup_snap <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cyc_start && addr_hit) begin
                        state    <= ST_ADDR;
                        ws_snap  <= ws;
                        ign_snap <= rdy_ign;
                        sup_snap <= suppress;
                    end
                end
                ST_ADDR: begin
                    if (ws_snap == '0) begin
                        state <= ST_DATA;
                    end else begin
                        state <= ST_WAIT;
                        wcnt  <= WS_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (wcnt == ws_snap) state <= ST_DATA;
                    else wcnt <= wcnt + WS_W'(1);
                end
                ST_DATA: begin
                    if (data_end) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Completion flag: one clock after the data phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= data_end;
    end

    assign lcs_n      = (state == ST_IDLE);
    assign addr_phase = (state == ST_ADDR);
    assign ad_oe      = addr_phase && !sup_snap;
    assign cyc_done   = done_q;

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);
    assert_done_after_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> (lcs_n && !$past(lcs_n)));
    assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> ((wcnt != '0) && (wcnt <= ws_snap)));
    assert_ignore_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DATA) && ign_snap) |=> lcs_n);
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lcs_n && !(cyc_start && addr_hit)) |=> lcs_n);
    assert_snap_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcs_n && !$past(lcs_n)) |-> ($stable(ws_snap) && $stable(ign_snap)));
endmodule

// File: rtl/csw_lowmem_ctl.sv
// Module: top of the low-memory chip-select controller. Joins the control
// register, the strap capture and the access sequencer. Assumes that the
// address decode and the bus-cycle start come from outside.
module csw_lowmem_ctl
    import csw_pkg::*;
#(
    parameter logic [WS_W-1:0] RST_WS = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_pin,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             psram_en,
    input  logic             cyc_start,
    input  logic             addr_hit,
    input  logic             ready_in,
    output logic             lcs_n,
    output logic             addr_phase,
    output logic             ad_oe,
    output logic             cyc_done
);
    cfg_t cfg;
    logic strap_hi;
    logic suppress;

    csw_cfg_reg #(.RST_WS(RST_WS)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    csw_strap_latch u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_pin (strap_pin),
        .strap_hi  (strap_hi)
    );

    assign suppress = cfg.da && strap_hi;
    assign psram_en = cfg.pse;

    csw_bus_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_start  (cyc_start),
        .addr_hit   (addr_hit),
        .ready_in   (ready_in),
        .ws         (cfg.ws),
        .rdy_ign    (cfg.rdy_ign),
        .suppress   (suppress),
        .lcs_n      (lcs_n),
        .addr_phase (addr_phase),
        .ad_oe      (ad_oe),
        .cyc_done   (cyc_done)
    );

    assert_strap_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && !strap_hi) |-> ad_oe);
    assert_drive_only_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (addr_phase && !lcs_n));
endmodule

// File: tb/test_csw_lowmem_ctl.sv
// Bench: directed corner cases plus seeded random settings and ready patterns.
module test_csw_lowmem_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_pin = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic [11:0] cfg_rdata;
    logic        psram_en;
    logic        cyc_start = 1'b0;
    logic        addr_hit = 1'b0;
    logic        ready_in = 1'b0;
    logic        lcs_n;
    logic        addr_phase;
    logic        ad_oe;
    logic        cyc_done;

    int checks = 0;
    int fails = 0;
    bit strap_now = 1'b1;

    csw_lowmem_ctl i_csw_lowmem_ctl (
        .clk(clk), .rst_n(rst_n), .strap_pin(strap_pin),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .psram_en(psram_en), .cyc_start(cyc_start), .addr_hit(addr_hit),
        .ready_in(ready_in), .lcs_n(lcs_n), .addr_phase(addr_phase),
        .ad_oe(ad_oe), .cyc_done(cyc_done)
    );

    always #2.5 clk = ~clk;

    function automatic logic [11:0] exp_rd(input logic [11:0] w);
        return 12'hF38 | (w & 12'h0C7);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit sv);
        rst_n = 1'b0;
        strap_pin = sv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        strap_pin = ~sv;
        strap_now = sv;
        chk(cfg_rdata == 12'hF3B, "R1 rdata", int'(cfg_rdata), 32'hF3B);
        chk(lcs_n == 1'b1, "R1 lcs_n", int'(lcs_n), 1);
        chk(cyc_done == 1'b0, "R1 cyc_done", int'(cyc_done), 0);
        chk(psram_en == 1'b0, "R1 psram_en", int'(psram_en), 0);
    endtask

    task automatic wr_cfg(input logic [11:0] w);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(cfg_rdata == exp_rd(w), "R2 readback", int'(cfg_rdata), int'(exp_rd(w)));
        chk(psram_en == w[6], "R2 psram_en", int'(psram_en), int'(w[6]));
    endtask

    // Runs one access using settings c; optionally writes mv and re-strobes in clock 2.
    task automatic run_cycle(input logic [11:0] c, input bit mid, input logic [11:0] mv);
        int ws;
        bit ign;
        bit exp_oe;
        int len;
        int exp_len;
        bit r;
        ws = int'(c[1:0]);
        ign = c[2];
        exp_oe = !(c[7] && strap_now);
        len = 0;
        exp_len = 0;
        @(negedge clk);
        cyc_start = 1'b1;
        addr_hit = 1'b1;
        ready_in = 1'b0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            cyc_start = 1'b0;
            cfg_wr = 1'b0;
            if (lcs_n) break;
            len++;
            if (i == 1) begin
                chk(addr_phase == 1'b1, "R7 addr_phase first", int'(addr_phase), 1);
                chk(ad_oe == exp_oe, strap_now ? "R7 ad_oe" : "R8 ad_oe override",
                    int'(ad_oe), int'(exp_oe));
            end
            if (i == 2) begin
                chk(addr_phase == 1'b0 && ad_oe == 1'b0, "R7 after addr phase",
                    int'({addr_phase, ad_oe}), 0);
                if (mid) begin
                    cfg_wr = 1'b1;
                    cfg_wdata = mv;
                    cyc_start = 1'b1;
                end
            end
            r = ($urandom % 2 == 1) || (i > 30);
            ready_in = r;
            if (exp_len == 0 && i >= 2 + ws && (ign || r)) exp_len = i;
        end
        chk(len == exp_len, ign ? "R4 length" : "R5 length", len, exp_len);
        chk(cyc_done == 1'b1, "R6 done pulse", int'(cyc_done), 1);
        @(negedge clk);
        chk(cyc_done == 1'b0 && lcs_n == 1'b1, mid ? "R9 no restart" : "R6 done single",
            int'({cyc_done, lcs_n}), 1);
        ready_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C5A1));
        do_reset(1'b1);
        // R2: field positions and reserved ones
        wr_cfg(12'h0C5);
        wr_cfg(12'hF00);
        // R3: start without hit is ignored
        @(negedge clk);
        cyc_start = 1'b1;
        addr_hit = 1'b0;
        @(negedge clk);
        cyc_start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(lcs_n == 1'b1, "R3 no hit", int'(lcs_n), 1);
            @(negedge clk);
        end
        // R7: suppression with strap high
        wr_cfg(12'h084);
        run_cycle(12'h084, 1'b0, '0);
        // R4 and R5: every wait count in both ready modes
        for (int w = 0; w < 4; w++) begin
            wr_cfg(12'h004 | 12'(w));
            run_cycle(12'h004 | 12'(w), 1'b0, '0);
            wr_cfg(12'(w));
            run_cycle(12'(w), 1'b0, '0);
        end
        // R9: mid-access write and second strobe
        wr_cfg(12'h007);
        run_cycle(12'h007, 1'b1, 12'h004);
        chk(cfg_rdata == exp_rd(12'h004), "R9 new value stored", int'(cfg_rdata),
            int'(exp_rd(12'h004)));
        run_cycle(12'h004, 1'b0, '0);
        // random settings
        for (int n = 0; n < 40; n++) begin
            logic [11:0] w;
            w = 12'($urandom);
            wr_cfg(w);
            run_cycle(w, 1'b0, '0);
        end
        // R8: strap low overrides suppression
        do_reset(1'b0);
        wr_cfg(12'h085);
        run_cycle(12'h085, 1'b0, '0);
        wr_cfg(12'h080);
        run_cycle(12'h080, 1'b0, '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule